// File: doc/BRIEF.md
# Dual-Issue Register Interlock Scoreboard

This block sits between decode and issue in a two-wide in-order pipeline and decides, every cycle, which of the two decoded instructions may leave decode. Each slot gives up to two source register indices, one destination index, a producer latency class for the destination, and a flag that marks the second source as a dynamic shift amount. The block keeps a small countdown per tracked register. The tracked registers are the general registers, the floating-point registers and the floating-point status register, all in one index space. A consumer stalls until the countdown of each register it reads has run out.

The countdown starts when the producer issues, so a consumer that arrives later waits only for what is left. The wait also depends on how the value is used: a loaded value used as a shift amount needs one more cycle than the same value used any other way. Paired writes to a register pair can make the two halves ready at different times. Two instructions that arrive together may not issue together if the second reads what the first writes. A synchronous flush clears every pending result.

Top module: `isu_interlock`

## Requirements
- R1: After synchronous reset every register is ready. Slots that read any register are not stalled, and `pair_issue_o` is 1 when both slots are valid.
- R2: A producer of class 0 (fast: moves and simple ALU operations) never stalls a dependent instruction in the next cycle.
- R3: When both slots are valid and slot 1 reads a register that slot 0 writes, including either half of a pair that slot 0 writes, slot 1 stalls (`stall_o[1]`=1) and slot 0 may still issue. Stall bit i belongs to slot i.
- R4: A class 1 producer (memory load) has a 2-cycle latency measured from its issue cycle. A reader that arrives one cycle after the load stalls for exactly 1 cycle.
- R5: When the second source of a reader has its shift-amount flag set, the latency of a class 1 producer seen by that source is 3 cycles. Plain readers of the same register still see 2 cycles.
- R6: A class 2 producer (status-register write, destination index NGPR+NFPR) has a 4-cycle latency: a reader stalls in the 3 cycles after the write issues.
- R7: A class 3 producer (conversion to a register pair) writes the even/odd pair that holds its destination index (bit 0 ignored). Both halves become ready 3 cycles after issue.
- R8: A class 4 producer (vector transform into a register pair) makes the odd register ready after 7 cycles and the even register after 8 cycles.
- R9: A stalled slot records no latency. While slot 0 stalls, slot 1 also stalls and records no latency.
- R10: When several writes to one register are in flight, in the same cycle or in different cycles, the register stays busy until the longest of them completes.
- R11: With `flush_i` high, every valid slot stalls and nothing is recorded. From the next cycle every register is ready.
- R12: `pair_issue_o` is 1 exactly when both slots are valid and neither is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Synchronous clear of all pending results |
| slot_vld_i | input | 2 | Slot holds a decoded instruction |
| src_a_en_i | input | 2 | First source in use, per slot |
| src_a_idx_i | input | 2xIW | First source index, per slot |
| src_b_en_i | input | 2 | Second source in use, per slot |
| src_b_idx_i | input | 2xIW | Second source index, per slot |
| src_b_shamt_i | input | 2 | Second source is a dynamic shift amount |
| dst_en_i | input | 2 | Slot writes a destination |
| dst_idx_i | input | 2xIW | Destination index (general 0..NGPR-1, float next, status last) |
| dst_cls_i | input | 2x3 | Producer latency class 0..4 |
| stall_o | output | 2 | Slot i may not issue this cycle |
| pair_issue_o | output | 1 | Both slots issue this cycle |

## Verification
The bench targets the remaining-latency rule: a load followed one cycle later by a reader has to give one stall cycle, and a design that reloads the full latency would give two. It splits one loaded register between a plain reader and a shift-amount reader in the same cycle. A design without the per-use count would stall both or neither. It also walks a pair transform to the 7th and 8th cycles, and a design that tracks pairs as one register would free or hold both halves together. Finally it overlaps a short write with a long one on the same register, where an overwriting counter would free the register too early, and checks that a held slot 1 and a flushed pipeline leave no latency behind.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int NSLOT  = 2;
  localparam int NTGT_S = 2;                 // write targets per slot (pair halves)
  localparam int NTGT   = NSLOT * NTGT_S;

  typedef enum logic [2:0] {
    LC_FAST  = 3'd0,
    LC_LOAD  = 3'd1,
    LC_STAT  = 3'd2,
    LC_CVT   = 3'd3,
    LC_XFORM = 3'd4
  } lat_cls_e;
endpackage

// File: rtl/isu_lat_decode.sv
module isu_lat_decode
  import isu_pkg::*;
#(
  parameter int IW             = 6,
  parameter int CW             = 4,
  parameter int LAT_LOAD       = 2,
  parameter int LAT_LOAD_SHAMT = 3,
  parameter int LAT_STAT       = 4,
  parameter int LAT_CVT        = 3,
  parameter int LAT_XF_LO      = 7,
  parameter int LAT_XF_HI      = 8
) (
  input  logic                      dst_en_i,
  input  logic [IW-1:0]             dst_idx_i,
  input  logic [2:0]                cls_i,
  output logic [NTGT_S-1:0]         t_en_o,
  output logic [NTGT_S-1:0][IW-1:0] t_idx_o,
  output logic [NTGT_S-1:0][CW-1:0] t_norm_o,
  output logic [NTGT_S-1:0][CW-1:0] t_shamt_o
);
  // countdown values loaded at issue: a consumer may go when the count is zero
  localparam logic [CW-1:0] C_LOAD = CW'(LAT_LOAD - 1);
  localparam logic [CW-1:0] C_LSH  = CW'(LAT_LOAD_SHAMT - 1);
  localparam logic [CW-1:0] C_STAT = CW'(LAT_STAT - 1);
  localparam logic [CW-1:0] C_CVT  = CW'(LAT_CVT - 1);
  localparam logic [CW-1:0] C_XLO  = CW'(LAT_XF_LO - 1);
  localparam logic [CW-1:0] C_XHI  = CW'(LAT_XF_HI - 1);

  logic [IW-1:0] even_idx, odd_idx;
  assign even_idx = {dst_idx_i[IW-1:1], 1'b0};
  assign odd_idx  = {dst_idx_i[IW-1:1], 1'b1};

  always_comb begin
    t_en_o    = {1'b0, dst_en_i};
    t_idx_o   = {dst_idx_i, dst_idx_i};
    t_norm_o  = '0;
    t_shamt_o = '0;
    case (lat_cls_e'(cls_i))
      LC_LOAD: begin
        t_norm_o[0]  = C_LOAD;
        t_shamt_o[0] = C_LSH;
      end
      LC_STAT: begin
        t_norm_o[0]  = C_STAT;
        t_shamt_o[0] = C_STAT;
      end
      LC_CVT: begin
        t_en_o    = {2{dst_en_i}};
        t_idx_o   = {odd_idx, even_idx};
        t_norm_o  = {C_CVT, C_CVT};
        t_shamt_o = {C_CVT, C_CVT};
      end
      LC_XFORM: begin
        t_en_o    = {2{dst_en_i}};
        t_idx_o   = {odd_idx, even_idx};
        t_norm_o  = {C_XLO, C_XHI};
        t_shamt_o = {C_XLO, C_XHI};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/isu_reg_track.sv
module isu_reg_track #(
  parameter int NREG = 33,
  parameter int IW   = 6,
  parameter int CW   = 4,
  parameter int NT   = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_i,
  input  logic                  flush_i,
  input  logic [NT-1:0]         w_en_i,
  input  logic [NT-1:0][IW-1:0] w_idx_i,
  input  logic [NT-1:0][CW-1:0] w_norm_i,
  input  logic [NT-1:0][CW-1:0] w_shamt_i,
  output logic [NREG-1:0]       busy_norm_o,
  output logic [NREG-1:0]       busy_shamt_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [CW-1:0] cn_q, cs_q, cn_d, cs_d;
    logic          hit;

    always_comb begin
      cn_d = (cn_q != '0) ? cn_q - CW'(1) : '0;
      cs_d = (cs_q != '0) ? cs_q - CW'(1) : '0;
      hit  = 1'b0;
      for (int t = 0; t < NT; t++) begin
        if (w_en_i[t] && w_idx_i[t] == IW'(r)) begin
          hit = 1'b1;
          if (w_norm_i[t] > cn_d)  cn_d = w_norm_i[t];
          if (w_shamt_i[t] > cs_d) cs_d = w_shamt_i[t];
        end
      end
    end

    always_ff @(posedge clk_i) begin
      if (rst_i || flush_i) begin
        cn_q <= '0;
        cs_q <= '0;
      end else begin
        cn_q <= cn_d;
        cs_q <= cs_d;
      end
    end

    assign busy_norm_o[r]  = (cn_q != '0);
    assign busy_shamt_o[r] = (cs_q != '0);

    // R5: the shift-amount view is never ready before the plain view
    assert_shamt_covers_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      cs_q >= cn_q);
    // R4: without a new write, a pending count drops by exactly one per cycle
    assert_countdown_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (!flush_i && !hit && cn_q != '0) |=> cn_q == $past(cn_q) - CW'(1));
    // R11: flush leaves the register ready
    assert_flush_clear_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      flush_i |=> (cn_q == '0 && cs_q == '0));
  end
endmodule

// File: rtl/isu_hazard_check.sv
module isu_hazard_check #(
  parameter int NREG = 33,
  parameter int IW   = 6
) (
  input  logic            vld_i,
  input  logic            a_en_i,
  input  logic [IW-1:0]   a_idx_i,
  input  logic            b_en_i,
  input  logic [IW-1:0]   b_idx_i,
  input  logic            b_shamt_i,
  input  logic [NREG-1:0] busy_norm_i,
  input  logic [NREG-1:0] busy_shamt_i,
  output logic            blocked_o
);
  localparam int SPAN = 2 ** IW;

  // indices beyond the tracked set read as ready
  logic [SPAN-1:0] pad_n, pad_s;
  assign pad_n = SPAN'(busy_norm_i);
  assign pad_s = SPAN'(busy_shamt_i);

  logic a_busy, b_busy;
  assign a_busy = a_en_i && pad_n[a_idx_i];
  assign b_busy = b_en_i && (b_shamt_i ? pad_s[b_idx_i] : pad_n[b_idx_i]);

  assign blocked_o = vld_i && (a_busy || b_busy);
endmodule

// File: rtl/isu_interlock.sv
module isu_interlock
  import isu_pkg::*;
#(
  parameter int  NGPR           = 16,
  parameter int  NFPR           = 16,
  parameter int  LAT_LOAD       = 2,
  parameter int  LAT_LOAD_SHAMT = 3,
  parameter int  LAT_STAT       = 4,
  parameter int  LAT_CVT        = 3,
  parameter int  LAT_XF_LO      = 7,
  parameter int  LAT_XF_HI      = 8,
  localparam int NREG           = NGPR + NFPR + 1,
  localparam int IW             = $clog2(NREG),
  localparam int LAT_MAX        = (LAT_XF_HI > LAT_STAT) ? LAT_XF_HI : LAT_STAT,
  localparam int CW             = $clog2(LAT_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_i,
  input  logic                 flush_i,
  input  logic [1:0]           slot_vld_i,
  input  logic [1:0]           src_a_en_i,
  input  logic [1:0][IW-1:0]   src_a_idx_i,
  input  logic [1:0]           src_b_en_i,
  input  logic [1:0][IW-1:0]   src_b_idx_i,
  input  logic [1:0]           src_b_shamt_i,
  input  logic [1:0]           dst_en_i,
  input  logic [1:0][IW-1:0]   dst_idx_i,
  input  logic [1:0][2:0]      dst_cls_i,
  output logic [1:0]           stall_o,
  output logic                 pair_issue_o
);
  logic [NSLOT-1:0][NTGT_S-1:0]         dec_en;
  logic [NSLOT-1:0][NTGT_S-1:0][IW-1:0] dec_idx;
  logic [NSLOT-1:0][NTGT_S-1:0][CW-1:0] dec_norm, dec_shamt;
  logic [NSLOT-1:0]                     sb_blk, issue;
  logic [NTGT-1:0]                      w_en;
  logic [NTGT-1:0][IW-1:0]              w_idx;
  logic [NTGT-1:0][CW-1:0]              w_norm, w_shamt;
  logic [NREG-1:0]                      busy_norm, busy_shamt;
  logic                                 raw01;

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    isu_lat_decode #(
      .IW(IW), .CW(CW), .LAT_LOAD(LAT_LOAD), .LAT_LOAD_SHAMT(LAT_LOAD_SHAMT),
      .LAT_STAT(LAT_STAT), .LAT_CVT(LAT_CVT), .LAT_XF_LO(LAT_XF_LO), .LAT_XF_HI(LAT_XF_HI)
    ) dec_i (
      .dst_en_i (dst_en_i[s]),
      .dst_idx_i(dst_idx_i[s]),
      .cls_i    (dst_cls_i[s]),
      .t_en_o   (dec_en[s]),
      .t_idx_o  (dec_idx[s]),
      .t_norm_o (dec_norm[s]),
      .t_shamt_o(dec_shamt[s])
    );

    isu_hazard_check #(.NREG(NREG), .IW(IW)) haz_i (
      .vld_i       (slot_vld_i[s]),
      .a_en_i      (src_a_en_i[s]),
      .a_idx_i     (src_a_idx_i[s]),
      .b_en_i      (src_b_en_i[s]),
      .b_idx_i     (src_b_idx_i[s]),
      .b_shamt_i   (src_b_shamt_i[s]),
      .busy_norm_i (busy_norm),
      .busy_shamt_i(busy_shamt),
      .blocked_o   (sb_blk[s])
    );

    for (genvar k = 0; k < NTGT_S; k++) begin : g_tgt
      assign w_en[s*NTGT_S+k]    = dec_en[s][k] && issue[s];
      assign w_idx[s*NTGT_S+k]   = dec_idx[s][k];
      assign w_norm[s*NTGT_S+k]  = dec_norm[s][k];
      assign w_shamt[s*NTGT_S+k] = dec_shamt[s][k];
    end
  end

  // slot 1 reads something slot 0 writes in the same cycle
  always_comb begin
    raw01 = 1'b0;
    for (int k = 0; k < NTGT_S; k++) begin
      if (slot_vld_i[0] && dec_en[0][k]) begin
        if (src_a_en_i[1] && src_a_idx_i[1] == dec_idx[0][k]) raw01 = 1'b1;
        if (src_b_en_i[1] && src_b_idx_i[1] == dec_idx[0][k]) raw01 = 1'b1;
      end
    end
  end

  assign stall_o[0]   = slot_vld_i[0] && (flush_i || sb_blk[0]);
  assign stall_o[1]   = slot_vld_i[1] && (flush_i || stall_o[0] || sb_blk[1] || raw01);
  assign issue        = slot_vld_i & ~stall_o;
  assign pair_issue_o = issue[0] && issue[1];

  isu_reg_track #(.NREG(NREG), .IW(IW), .CW(CW), .NT(NTGT)) trk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .flush_i     (flush_i),
    .w_en_i      (w_en),
    .w_idx_i     (w_idx),
    .w_norm_i    (w_norm),
    .w_shamt_i   (w_shamt),
    .busy_norm_o (busy_norm),
    .busy_shamt_o(busy_shamt)
  );

  assert_pair_raw_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (slot_vld_i == 2'b11 && dst_en_i[0] && dst_cls_i[0] == 3'd0 &&
     src_a_en_i[1] && src_a_idx_i[1] == dst_idx_i[0]) |-> stall_o[1]);
  assert_hold_later_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (stall_o[0] && slot_vld_i[1]) |-> stall_o[1]);
  assert_flush_blocks_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    flush_i |-> (stall_o == slot_vld_i && !pair_issue_o));
  assert_pair_clean_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    pair_issue_o |-> (slot_vld_i == 2'b11 && stall_o == 2'b00));
  assert_stall_needs_valid_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    (stall_o & ~slot_vld_i) == 2'b00);
endmodule

// File: tb/isu_interlock_tb_top.sv
module isu_interlock_tb_top;
  localparam int IW = 6;
  localparam int STATREG = 32;
  localparam logic [2:0] FAST = 3'd0, LOAD = 3'd1, STAT = 3'd2, CVT = 3'd3, XFORM = 3'd4;

  logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
  logic [1:0] vld, a_en, b_en, b_sh, d_en;
  logic [1:0][IW-1:0] a_idx, b_idx, d_idx;
  logic [1:0][2:0] d_cls;
  logic [1:0] stall;
  logic pair;

  // staged values applied by go()
  logic [1:0] n_vld, n_a_en, n_b_en, n_b_sh, n_d_en;
  logic [1:0][IW-1:0] n_a_idx, n_b_idx, n_d_idx;
  logic [1:0][2:0] n_d_cls;
  logic n_flush;

  logic [2:0] exp_q[$];
  string      tag_q[$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  isu_interlock dut_i (
    .clk_i(clk), .rst_i(rst), .flush_i(flush), .slot_vld_i(vld),
    .src_a_en_i(a_en), .src_a_idx_i(a_idx), .src_b_en_i(b_en), .src_b_idx_i(b_idx),
    .src_b_shamt_i(b_sh), .dst_en_i(d_en), .dst_idx_i(d_idx), .dst_cls_i(d_cls),
    .stall_o(stall), .pair_issue_o(pair)
  );

  task automatic clr();
    n_vld = '0; n_a_en = '0; n_b_en = '0; n_b_sh = '0; n_d_en = '0;
    n_a_idx = '0; n_b_idx = '0; n_d_idx = '0; n_d_cls = '0; n_flush = 1'b0;
  endtask

  task automatic rd(int s, int a, int b, bit sh);
    n_vld[s] = 1'b1;
    if (a >= 0) begin n_a_en[s] = 1'b1; n_a_idx[s] = IW'(a); end
    if (b >= 0) begin n_b_en[s] = 1'b1; n_b_idx[s] = IW'(b); n_b_sh[s] = sh; end
  endtask

  task automatic wr(int s, int d, logic [2:0] c);
    n_vld[s] = 1'b1; n_d_en[s] = 1'b1; n_d_idx[s] = IW'(d); n_d_cls[s] = c;
  endtask

  // driver: apply one cycle of stimulus and queue what must come out
  task automatic go(logic [1:0] es, logic ep, string tag);
    @(negedge clk); #1;
    vld = n_vld; a_en = n_a_en; a_idx = n_a_idx; b_en = n_b_en; b_idx = n_b_idx;
    b_sh = n_b_sh; d_en = n_d_en; d_idx = n_d_idx; d_cls = n_d_cls; flush = n_flush;
    exp_q.push_back({es, ep});
    tag_q.push_back(tag);
    clr();
  endtask

  // monitor: compare mid-cycle, well away from the rising edge
  initial begin
    forever begin
      @(negedge clk); #8;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({stall, pair} !== e) begin
          errors++;
          $display("FAIL %s: stall=%b pair=%b expected stall=%b pair=%b", t, stall, pair, e[2:1], e[0]);
        end
      end
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr();
    vld = '0; a_en = '0; b_en = '0; b_sh = '0; d_en = '0;
    a_idx = '0; b_idx = '0; d_idx = '0; d_cls = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1: all ready after reset
    rd(0, 5, -1, 0); rd(1, 6, 7, 0); go(2'b00, 1, "R1");
    // R2: fast producer, reader next cycle
    wr(0, 1, FAST); go(2'b00, 0, "R2");
    rd(0, 1, -1, 0); go(2'b00, 0, "R2");
    // R3: same-cycle read of slot 0 destination
    wr(0, 2, FAST); rd(1, 2, -1, 0); go(2'b10, 0, "R3");
    rd(0, 2, -1, 0); go(2'b00, 0, "R3");
    wr(0, 18, CVT); rd(1, -1, 19, 0); go(2'b10, 0, "R3 pair half");
    rd(0, 30, -1, 0); go(2'b00, 0, "R3");
    // R4: load, reader one cycle later waits one cycle
    wr(0, 3, LOAD); rd(1, 3, -1, 0); go(2'b10, 0, "R4");
    rd(0, 3, -1, 0); go(2'b01, 0, "R4");
    rd(0, 3, -1, 0); go(2'b00, 0, "R4");
    // R5: shift-amount use of a loaded value
    wr(0, 4, LOAD); go(2'b00, 0, "R5");
    rd(0, -1, 4, 1); go(2'b01, 0, "R5");
    rd(0, -1, 4, 0); rd(1, -1, 4, 1); go(2'b10, 0, "R5 split");
    rd(0, -1, 4, 1); go(2'b00, 0, "R5");
    // R6 + R9: status write, held slots record nothing
    wr(0, STATREG, STAT); go(2'b00, 0, "R6");
    rd(0, STATREG, -1, 0); wr(1, 9, LOAD); go(2'b11, 0, "R9 hold");
    rd(0, STATREG, -1, 0); wr(0, 10, LOAD); go(2'b01, 0, "R6");
    rd(0, STATREG, -1, 0); go(2'b01, 0, "R6");
    rd(0, STATREG, -1, 0); rd(1, 9, 10, 0); go(2'b00, 1, "R9 no record");
    // R7: conversion pair, both halves at 3
    wr(0, 16, CVT); go(2'b00, 0, "R7");
    rd(0, 16, -1, 0); go(2'b01, 0, "R7");
    rd(0, 17, -1, 0); go(2'b01, 0, "R7");
    rd(0, 16, -1, 0); rd(1, 17, -1, 0); go(2'b00, 1, "R7");
    // R8: transform pair, odd at 7, even at 8
    wr(0, 20, XFORM); go(2'b00, 0, "R8");
    for (int k = 1; k <= 6; k++) begin
      rd(0, 21, -1, 0); go(2'b01, 0, "R8 odd");
    end
    rd(0, 21, -1, 0); rd(1, 20, -1, 0); go(2'b10, 0, "R8 split");
    rd(0, 20, -1, 0); go(2'b00, 0, "R8 even");
    // R10: longer pending write survives a shorter one
    wr(0, 24, XFORM); go(2'b00, 0, "R10");
    wr(0, 25, FAST); go(2'b00, 0, "R10");
    rd(0, 25, -1, 0); go(2'b01, 0, "R10 keep max");
    wr(0, 12, LOAD); wr(1, 12, FAST); go(2'b00, 1, "R10 same cycle");
    rd(0, 12, -1, 0); go(2'b01, 0, "R10 same cycle");
    // R11: flush blocks and clears
    n_flush = 1'b1; rd(0, 24, -1, 0); rd(1, 5, -1, 0); go(2'b11, 0, "R11 flush");
    rd(0, 24, -1, 0); rd(1, 25, -1, 0); go(2'b00, 1, "R11 cleared");
    // R12: single valid slot never reports a pair
    rd(1, 7, -1, 0); go(2'b00, 0, "R12");

    go(2'b00, 0, "idle");
    @(negedge clk); @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule